// File: doc/BRIEF.md
# Raster Timing Counter with Interlace Support

This block keeps the horizontal dot position and the vertical scanline position of a video raster. It advances once for every dot enable pulse, which the surrounding chip raises every fourth master cycle. The length of a frame depends on the interlace mode and on a frame parity bit that toggles each frame. In progressive (non-interlaced) mode, one fixed scanline loses one dot on every odd frame.

The counter also produces two timing events for the rest of the chip. At the start of vertical blanking it sets a blanking flag. If the interrupt enable input is high, it also pulses a non-maskable interrupt request toward the processor. Once per scanline, near a fixed dot, it pulses a request to stall the processor for a memory refresh. That request fires only on a dot enable that lands on a master-clock count that is a multiple of eight.

Top module: `raster_timer`

## Requirements
- R1: After reset, `dotPos`=0, `linePos`=0, `oddFrame`=0, `vblankFlag`=0, `nmiReq`=0 and `refreshStall`=0.
- R2: `dotPos` and `linePos` change only on a clock edge where `dotEn` is 1. On such an edge `dotPos` increments. After the last dot of a line, `dotPos` returns to 0 and `linePos` increments. A normal line has DOTS dots (0..DOTS-1).
- R3: When `interlace`=0, every frame has LINES scanlines (0..LINES-1), whatever the parity.
- R4: When `interlace`=1, a frame with `oddFrame`=1 has LINES scanlines and a frame with `oddFrame`=0 has LINES+1. If the mode drops to progressive while the line number is past the new last line, the frame wraps at the next line end.
- R5: When `interlace`=0 and `oddFrame`=1, scanline SHORT_LINE has DOTS-1 dots. In all other cases that line has DOTS dots.
- R6: When the frame wraps to scanline 0, `oddFrame` toggles and `vblankFlag` clears, on the same edge.
- R7: On the edge where `linePos` becomes VBLANK_LINE, `vblankFlag` sets. On that same edge, `nmiReq` goes to 1 for one cycle, but only if `nmiEnable` is 1.
- R8: On a `dotEn` edge where `dotPos` (before the edge) is REFRESH_DOT or REFRESH_DOT+1 and `mclkLow`=0, `refreshStall` goes to 1 for one cycle, unless a stall was already requested on this line.
- R9: `refreshStall` pulses at most once per scanline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dotEn | input | 1 | Dot advance enable (one pulse per dot) |
| interlace | input | 1 | 1 = interlaced frame timing |
| nmiEnable | input | 1 | Allows the blanking interrupt request |
| mclkLow | input | 3 | Low three bits of the master-cycle count |
| dotPos | output | $clog2(DOTS) | Current dot within the line |
| linePos | output | $clog2(LINES+1) | Current scanline |
| oddFrame | output | 1 | Frame parity bit |
| nmiReq | output | 1 | One-cycle interrupt request at blanking start |
| vblankFlag | output | 1 | Set from blanking start until frame wrap |
| refreshStall | output | 1 | One-cycle request for a refresh stall |

## Verification
The bench builds the counter with DOTS=20, LINES=12, VBLANK_LINE=8, SHORT_LINE=9 and REFRESH_DOT=5. A frame is then only a few hundred clocks long, so every position of every frame can be compared against an arithmetic model. Over several frames the bench covers both parities in both modes, a mode switch, and the shortened line. Irregular dot enables and biased master-clock bits cause refresh requests to land on the first window dot, on the second, or not at all.

// File: rtl/raster_timer_pkg.sv
package raster_timer_pkg;
  typedef struct packed {
    logic lineEnd;
    logic frameEnd;
    logic vblankHit;
    logic stallHit;
  } stepT;
endpackage

// File: rtl/raster_timer_ctrl.sv
module raster_timer_ctrl
  import raster_timer_pkg::*;
#(
  parameter int DOTS        = 341,
  parameter int LINES       = 262,
  parameter int VBLANK_LINE = 225,
  parameter int SHORT_LINE  = 240,
  parameter int REFRESH_DOT = 134,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(LINES + 1)
) (
  input  logic              dotEn,
  input  logic              interlace,
  input  logic [2:0]        mclkLow,
  input  logic [DOT_W-1:0]  dotPos,
  input  logic [LINE_W-1:0] linePos,
  input  logic              oddFrame,
  input  logic              refreshDone,
  output stepT              step
);
  localparam logic [DOT_W-1:0]  LAST_DOT   = DOT_W'(DOTS - 1);
  localparam logic [DOT_W-1:0]  SHORT_DOT  = DOT_W'(DOTS - 2);
  localparam logic [DOT_W-1:0]  REF_A      = DOT_W'(REFRESH_DOT);
  localparam logic [DOT_W-1:0]  REF_B      = DOT_W'(REFRESH_DOT + 1);
  localparam logic [LINE_W-1:0] LAST_SHORT = LINE_W'(LINES - 1);
  localparam logic [LINE_W-1:0] LAST_LONG  = LINE_W'(LINES);
  localparam logic [LINE_W-1:0] PRE_VBL    = LINE_W'(VBLANK_LINE - 1);
  localparam logic [LINE_W-1:0] CUT_LINE   = LINE_W'(SHORT_LINE);

  logic [DOT_W-1:0]  lastDot;
  logic [LINE_W-1:0] lastLine;
  logic              cutActive;

  always_comb begin
    cutActive = !interlace && oddFrame && (linePos == CUT_LINE);
    lastDot   = cutActive ? SHORT_DOT : LAST_DOT;
    lastLine  = (interlace && !oddFrame) ? LAST_LONG : LAST_SHORT;
    step.lineEnd   = dotEn && (dotPos >= lastDot);
    step.frameEnd  = step.lineEnd && (linePos >= lastLine);
    step.vblankHit = step.lineEnd && !step.frameEnd && (linePos == PRE_VBL);
    step.stallHit  = dotEn && !refreshDone && (mclkLow == 3'd0) &&
                     ((dotPos == REF_A) || (dotPos == REF_B));
  end
endmodule

// File: rtl/raster_timer_dp.sv
module raster_timer_dp
  import raster_timer_pkg::*;
#(
  parameter int DOTS        = 341,
  parameter int LINES       = 262,
  parameter int VBLANK_LINE = 225,
  parameter int REFRESH_DOT = 134,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dotEn,
  input  logic              nmiEnable,
  input  logic [2:0]        mclkLow,
  input  stepT              step,
  output logic [DOT_W-1:0]  dotPos,
  output logic [LINE_W-1:0] linePos,
  output logic              oddFrame,
  output logic              vblankFlag,
  output logic              nmiReq,
  output logic              refreshStall,
  output logic              refreshDone
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dotPos       <= '0;
      linePos      <= '0;
      oddFrame     <= 1'b0;
      vblankFlag   <= 1'b0;
      nmiReq       <= 1'b0;
      refreshStall <= 1'b0;
      refreshDone  <= 1'b0;
    end else begin
      nmiReq       <= step.vblankHit && nmiEnable;
      refreshStall <= step.stallHit;
      if (step.lineEnd) begin
        dotPos      <= '0;
        refreshDone <= 1'b0;
        if (step.frameEnd) begin
          linePos    <= '0;
          oddFrame   <= !oddFrame;
          vblankFlag <= 1'b0;
        end else begin
          linePos <= linePos + 1'b1;
          if (step.vblankHit) vblankFlag <= 1'b1;
        end
      end else if (dotEn) begin
        dotPos <= dotPos + 1'b1;
        if (step.stallHit) refreshDone <= 1'b1;
      end
    end
  end

  a_r2_dot_bound: assert property (@(posedge clk) disable iff (!rstN)
    dotPos <= DOT_W'(DOTS - 1));
  a_r2_hold_without_enable: assert property (@(posedge clk) disable iff (!rstN)
    !dotEn |=> $stable(dotPos) && $stable(linePos));
  a_r4_line_bound: assert property (@(posedge clk) disable iff (!rstN)
    linePos <= LINE_W'(LINES));
  a_r6_parity_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(oddFrame) |-> (linePos == '0) && !vblankFlag);
  a_r7_req_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> vblankFlag && (linePos == LINE_W'(VBLANK_LINE)));
  a_r8_stall_window: assert property (@(posedge clk) disable iff (!rstN)
    step.stallHit |=> refreshStall && ((dotPos == DOT_W'(REFRESH_DOT + 1)) ||
                                      (dotPos == DOT_W'(REFRESH_DOT + 2))));
  a_r8_stall_aligned: assert property (@(posedge clk) disable iff (!rstN)
    step.stallHit |-> (mclkLow == 3'd0));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    refreshStall |=> !refreshStall);
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import raster_timer_pkg::*;
#(
  parameter int DOTS        = 341,
  parameter int LINES       = 262,
  parameter int VBLANK_LINE = 225,
  parameter int SHORT_LINE  = 240,
  parameter int REFRESH_DOT = 134,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dotEn,
  input  logic              interlace,
  input  logic              nmiEnable,
  input  logic [2:0]        mclkLow,
  output logic [DOT_W-1:0]  dotPos,
  output logic [LINE_W-1:0] linePos,
  output logic              oddFrame,
  output logic              nmiReq,
  output logic              vblankFlag,
  output logic              refreshStall
);
  stepT step;
  logic refreshDone;

  raster_timer_ctrl #(
    .DOTS(DOTS), .LINES(LINES), .VBLANK_LINE(VBLANK_LINE),
    .SHORT_LINE(SHORT_LINE), .REFRESH_DOT(REFRESH_DOT)
  ) u_ctrl (
    .dotEn(dotEn), .interlace(interlace), .mclkLow(mclkLow),
    .dotPos(dotPos), .linePos(linePos), .oddFrame(oddFrame),
    .refreshDone(refreshDone), .step(step)
  );

  raster_timer_dp #(
    .DOTS(DOTS), .LINES(LINES), .VBLANK_LINE(VBLANK_LINE),
    .REFRESH_DOT(REFRESH_DOT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dotEn(dotEn), .nmiEnable(nmiEnable),
    .mclkLow(mclkLow), .step(step), .dotPos(dotPos), .linePos(linePos),
    .oddFrame(oddFrame), .vblankFlag(vblankFlag), .nmiReq(nmiReq),
    .refreshStall(refreshStall), .refreshDone(refreshDone)
  );
endmodule

// File: tb/raster_timer_tb.sv
module raster_timer_tb;
  localparam int D = 20, L = 12, V = 8, S = 9, R = 5;
  localparam int DW = $clog2(D), LW = $clog2(L + 1);

  logic clk = 1'b0, rstN = 1'b0, dotEn = 1'b0, interlace = 1'b0, nmiEnable = 1'b0;
  logic [2:0] mclkLow = 3'd0;
  logic [DW-1:0] dotPos;
  logic [LW-1:0] linePos;
  logic oddFrame, nmiReq, vblankFlag, refreshStall;

  raster_timer #(.DOTS(D), .LINES(L), .VBLANK_LINE(V), .SHORT_LINE(S),
                 .REFRESH_DOT(R)) u_dut (
    .clk(clk), .rstN(rstN), .dotEn(dotEn), .interlace(interlace),
    .nmiEnable(nmiEnable), .mclkLow(mclkLow), .dotPos(dotPos),
    .linePos(linePos), .oddFrame(oddFrame), .nmiReq(nmiReq),
    .vblankFlag(vblankFlag), .refreshStall(refreshStall));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  int mDot = 0, mLine = 0, mOdd = 0, mFlag = 0, mReq = 0, mStall = 0, mDone = 0;
  int stallsThisLine = 0, stallsSeen = 0, reqSeen = 0, cutSeen = 0, longSeen = 0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (line %0d dot %0d)", tag, act, exp, mLine, mDot);
    end
  endtask

  task automatic modelStep();
    int lastDot, lastLine;
    bit stall;
    mReq = 0;
    stall = dotEn && (mDot == R || mDot == R + 1) && mclkLow == 0 && !mDone;
    mStall = stall;
    if (!dotEn) return;
    lastDot = (mLine == S && mOdd == 1 && !interlace) ? D - 2 : D - 1;
    lastLine = (interlace && mOdd == 0) ? L : L - 1;
    if (mDot >= lastDot) begin
      if (lastDot == D - 2) cutSeen++;
      mDot = 0; mDone = 0; stallsThisLine = 0;
      if (mLine >= lastLine) begin
        if (mLine == L) longSeen++;
        mLine = 0; mOdd ^= 1; mFlag = 0;
      end else begin
        mLine++;
        if (mLine == V) begin mFlag = 1; mReq = nmiEnable; end
      end
    end else begin
      mDot++;
      if (stall) mDone = 1;
    end
  endtask

  task automatic compareAll();
    check("R2/R5 dotPos", dotPos, mDot);
    check("R3/R4 linePos", linePos, mLine);
    check("R6 oddFrame", oddFrame, mOdd);
    check("R7 vblankFlag", vblankFlag, mFlag);
    check("R7 nmiReq", nmiReq, mReq);
    check("R8 refreshStall", refreshStall, mStall);
    if (refreshStall) begin stallsThisLine++; stallsSeen++; end
    if (nmiReq) reqSeen++;
    check("R9 stalls per line", stallsThisLine <= 1, 1);
  endtask

  task automatic runFrames(input bit il, input bit ne, input int frames);
    int wraps = 0;
    interlace = il; nmiEnable = ne;
    while (wraps < frames) begin
      @(negedge clk);
      modelStep();
      compareAll();
      if (dotEn && mDot == 0 && mLine == 0) wraps++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      dotEn = (lfsr[1:0] != 2'b00);
      mclkLow = lfsr[7:5] & lfsr[4:2];
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 dotPos", dotPos, 0);
    check("R1 linePos", linePos, 0);
    check("R1 oddFrame", oddFrame, 0);
    check("R1 vblankFlag", vblankFlag, 0);
    check("R1 nmiReq", nmiReq, 0);
    check("R1 refreshStall", refreshStall, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 hold without dotEn", dotPos, 0);
    runFrames(1'b0, 1'b1, 4);   // R3 R5 progressive
    runFrames(1'b1, 1'b0, 4);   // R4 interlaced, no request
    runFrames(1'b1, 1'b1, 3);
    // mode drop while on the extra line: R4 wrap guard
    while (!(mLine == L && mDot == 3)) begin
      @(negedge clk); modelStep(); compareAll();
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      dotEn = (lfsr[1:0] != 2'b00); mclkLow = lfsr[7:5] & lfsr[4:2];
    end
    runFrames(1'b0, 1'b1, 3);
    check("R5 short line exercised", cutSeen > 0, 1);
    check("R4 long frame exercised", longSeen > 0, 1);
    check("R7 requests observed", reqSeen > 0, 1);
    check("R8 stalls observed", stallsSeen > 0, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule